// File: doc/BRIEF.md
# FPU exception and trap controller

This block sits beside an integer pipeline and owns the exception state of a floating-point unit. It holds the status word: the current and accrued IEEE exception flags, the trap enable mask, the trap-type field, a queue-not-empty flag and a read-only version field. It also holds a single-entry deferred-trap queue that records the PC and instruction word of the instruction that faulted.

An exception is not taken at once. A fault raised in execute mode captures the faulting instruction into the queue and moves the unit to a pending state. The next floating-point instruction that issues turns the pending state into a trap request, which is a one-cycle pulse carrying a 9-bit trap code. A floating-point instruction that issues while the unit is already in the exception state is discarded and marked as a sequence error. A queue-store request drains the entry back to software and returns the unit to execute mode. Arithmetic datapaths are outside this block. They report only their flags.

Top module: `fpx_trap_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (execute), trap_o is low, and status_o has every bit zero except bits 19:17, which show ver_sel_i.
- R2: An accepted arithmetic report replaces the current-exception field status_o[4:0] with arith_flags_i (bit 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact). A report with all flags zero therefore clears the field. When arith_flags_i AND the trap enable mask is zero, the flags are ORed into the accrued field status_o[9:5], and the mode stays execute.
- R3: When an accepted arithmetic report has a flag that is also set in the trap enable mask, the accrued field is unchanged. The trap type status_o[16:14] becomes 1 (IEEE exception), pc_i and insn_i are captured into q_pc_o and q_insn_o, the queue-not-empty bit status_o[13] is set, and mode_o becomes 1 (pending).
- R4: In execute mode, unimpl_i raises an exception with trap type 3 and badreg_i raises one with trap type 6. Each captures the instruction and enters pending mode.
- R5: An issue_i in pending mode sets mode_o to 2 (exception) and makes trap_o high for exactly the following cycle. The trap code is 0x008 when wide_i is 0. When wide_i is 1, the code is 0x021 if the trap type is 1 and 0x022 otherwise.
- R6: An issue_i in exception mode raises no trap and leaves the queue and the mode unchanged. It sets the trap type to 4 (sequence error).
- R7: A qstore_i while queue-not-empty is clear raises a sequence-error exception: trap type 4, capture of pc_i and insn_i, and pending mode.
- R8: A qstore_i while queue-not-empty is set leaves the queued PC and instruction readable on q_pc_o and q_insn_o. It clears queue-not-empty, returns the unit to execute mode and leaves the trap type unchanged.
- R9: Arithmetic, unimplemented and invalid-register reports are ignored outside execute mode. An issue_i in execute mode has no effect.
- R10: When several reports arrive in one execute-mode cycle, priority runs from sequence-error queue store, through invalid register, then unimplemented, to arithmetic. The lower-priority reports are dropped entirely.
- R11: tem_we_i loads tem_d_i into the trap enable field status_o[27:23].
- R12: Queue-not-empty is never set while the mode is execute. The mode never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | Selects the 64-bit trap code set |
| ver_sel_i | input | 3 | Version shown in the status word |
| pc_i | input | 32 | PC of the current FP instruction |
| insn_i | input | 32 | Instruction word of the current FP instruction |
| arith_valid_i | input | 1 | An arithmetic operation completed |
| arith_flags_i | input | 5 | IEEE flags of that operation |
| unimpl_i | input | 1 | Operation is unimplemented |
| badreg_i | input | 1 | Misaligned or invalid register number |
| issue_i | input | 1 | FP op, FP load or FP branch issued |
| qstore_i | input | 1 | Queue-store request |
| tem_we_i | input | 1 | Trap enable mask write strobe |
| tem_d_i | input | 5 | Trap enable mask write data |
| mode_o | output | 2 | 0 execute, 1 pending, 2 exception |
| status_o | output | 32 | Status word |
| trap_o | output | 1 | One-cycle trap request |
| trap_code_o | output | 9 | Trap code valid with trap_o |
| q_pc_o | output | 32 | Queued PC |
| q_insn_o | output | 32 | Queued instruction word |

## Verification
The assertions check, on every cycle, several invariants and local properties. The trap pulse lasts one cycle and occurs only in exception mode. Queue-not-empty is clear in execute mode. A capture loads the PC and instruction seen at the raising edge. A trapping arithmetic report leaves the accrued flags untouched, and a non-trapping one leaves its flags in the accrued field. Only the directed scenarios can show end-to-end behaviour. These include the choice of trap code for each width and trap type, sequence errors raised from the exception state and from an empty queue store, reports ignored outside execute mode, and the priority among reports that arrive in the same cycle.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {
    MODE_EXEC = 2'd0,
    MODE_PEND = 2'd1,
    MODE_EXCP = 2'd2
  } fpx_mode_e;

  localparam int unsigned EXC_W    = 5;
  localparam int unsigned FTT_W    = 3;
  localparam int unsigned VER_W    = 3;
  localparam int unsigned TRAP_W   = 9;
  localparam int unsigned STATUS_W = 32;

  localparam int unsigned CEXC_LSB = 0;
  localparam int unsigned AEXC_LSB = 5;
  localparam int unsigned QNE_BIT  = 13;
  localparam int unsigned FTT_LSB  = 14;
  localparam int unsigned VER_LSB  = 17;
  localparam int unsigned TEM_LSB  = 23;

  localparam logic [FTT_W-1:0] FTT_IEEE   = 3'd1;
  localparam logic [FTT_W-1:0] FTT_UNIMP  = 3'd3;
  localparam logic [FTT_W-1:0] FTT_SEQ    = 3'd4;
  localparam logic [FTT_W-1:0] FTT_BADREG = 3'd6;

  localparam logic [TRAP_W-1:0] TRAP_FP32    = 9'h008;
  localparam logic [TRAP_W-1:0] TRAP_IEEE64  = 9'h021;
  localparam logic [TRAP_W-1:0] TRAP_OTHER64 = 9'h022;
endpackage

// File: rtl/fpx_excp_unit.sv
module fpx_excp_unit
  import fpx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_exec_i,
  input  logic             in_excp_i,
  input  logic             qne_i,
  input  logic             qstore_i,
  input  logic             badreg_i,
  input  logic             unimpl_i,
  input  logic             arith_valid_i,
  input  logic [EXC_W-1:0] arith_flags_i,
  input  logic             issue_i,
  input  logic             tem_we_i,
  input  logic [EXC_W-1:0] tem_d_i,
  output logic             raise_o,
  output logic [EXC_W-1:0] cexc_o,
  output logic [EXC_W-1:0] aexc_o,
  output logic [FTT_W-1:0] ftt_o,
  output logic [EXC_W-1:0] tem_o
);
  logic             seq_req, bad_req, unimp_req, arith_acc, ieee_hit;
  logic [FTT_W-1:0] raise_ftt;

  // priority: empty-queue store, bad register, unimplemented, arithmetic
  always_comb begin
    seq_req   = in_exec_i & qstore_i & ~qne_i;
    bad_req   = in_exec_i & badreg_i & ~seq_req;
    unimp_req = in_exec_i & unimpl_i & ~seq_req & ~badreg_i;
    arith_acc = in_exec_i & arith_valid_i & ~seq_req & ~badreg_i & ~unimpl_i;
    ieee_hit  = arith_acc & (|(arith_flags_i & tem_o));
    raise_o   = seq_req | bad_req | unimp_req | ieee_hit;
    if (seq_req)        raise_ftt = FTT_SEQ;
    else if (bad_req)   raise_ftt = FTT_BADREG;
    else if (unimp_req) raise_ftt = FTT_UNIMP;
    else                raise_ftt = FTT_IEEE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cexc_o <= '0;
      aexc_o <= '0;
      ftt_o  <= '0;
      tem_o  <= '0;
    end else begin
      if (tem_we_i) tem_o <= tem_d_i;
      if (arith_acc) cexc_o <= arith_flags_i;
      if (arith_acc && !ieee_hit) aexc_o <= aexc_o | arith_flags_i;
      if (raise_o) ftt_o <= raise_ftt;
      else if (in_excp_i && issue_i && !qstore_i) ftt_o <= FTT_SEQ;
    end
  end

  assert_aexc_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ieee_hit |=> aexc_o == $past(aexc_o));

  assert_aexc_accrue_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arith_acc && !ieee_hit) |=> (aexc_o & $past(arith_flags_i)) == $past(arith_flags_i));

  assert_no_raise_outside_exec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_exec_i |=> $stable(cexc_o) && $stable(aexc_o));
endmodule

// File: rtl/fpx_trap_queue.sv
module fpx_trap_queue #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned INSN_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              drain_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [INSN_W-1:0] insn_i,
  output logic              qne_o,
  output logic [PC_W-1:0]   q_pc_o,
  output logic [INSN_W-1:0] q_insn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qne_o    <= 1'b0;
      q_pc_o   <= '0;
      q_insn_o <= '0;
    end else if (capture_i) begin
      qne_o    <= 1'b1;
      q_pc_o   <= pc_i;
      q_insn_o <= insn_i;
    end else if (drain_i) begin
      qne_o <= 1'b0;
    end
  end

  assert_capture_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> qne_o && q_pc_o == $past(pc_i) && q_insn_o == $past(insn_i));

  assert_drain_keeps_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_i && !capture_i) |=> !qne_o && $stable(q_pc_o) && $stable(q_insn_o));
endmodule

// File: rtl/fpx_mode_fsm.sv
module fpx_mode_fsm
  import fpx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raise_i,
  input  logic              issue_i,
  input  logic              drain_i,
  input  logic              wide_i,
  input  logic [FTT_W-1:0]  ftt_i,
  output fpx_mode_e         mode_o,
  output logic              trap_o,
  output logic [TRAP_W-1:0] trap_code_o
);
  fpx_mode_e         mode_d;
  logic              fire;
  logic [TRAP_W-1:0] code_d;

  always_comb begin
    mode_d = mode_o;
    fire   = 1'b0;
    unique case (mode_o)
      MODE_EXEC: if (raise_i) mode_d = MODE_PEND;
      MODE_PEND: begin
        if (drain_i) mode_d = MODE_EXEC;
        else if (issue_i) begin
          mode_d = MODE_EXCP;
          fire   = 1'b1;
        end
      end
      MODE_EXCP: if (drain_i) mode_d = MODE_EXEC;
      default:   mode_d = MODE_EXEC;
    endcase
    if (!wide_i)              code_d = TRAP_FP32;
    else if (ftt_i == FTT_IEEE) code_d = TRAP_IEEE64;
    else                      code_d = TRAP_OTHER64;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= MODE_EXEC;
      trap_o      <= 1'b0;
      trap_code_o <= '0;
    end else begin
      mode_o <= mode_d;
      trap_o <= fire;
      if (fire) trap_code_o <= code_d;
    end
  end

  assert_trap_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> !trap_o);

  assert_trap_in_excp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> mode_o == MODE_EXCP);

  assert_mode_legal_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);
endmodule

// File: rtl/fpx_trap_ctrl.sv
module fpx_trap_ctrl
  import fpx_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned INSN_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic [VER_W-1:0]  ver_sel_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic              arith_valid_i,
  input  logic [EXC_W-1:0]  arith_flags_i,
  input  logic              unimpl_i,
  input  logic              badreg_i,
  input  logic              issue_i,
  input  logic              qstore_i,
  input  logic              tem_we_i,
  input  logic [EXC_W-1:0]  tem_d_i,
  output logic [1:0]        mode_o,
  output logic [STATUS_W-1:0] status_o,
  output logic              trap_o,
  output logic [TRAP_W-1:0] trap_code_o,
  output logic [PC_W-1:0]   q_pc_o,
  output logic [INSN_W-1:0] q_insn_o
);
  fpx_mode_e        mode;
  logic             in_exec, in_excp, raise, qne, drain;
  logic [EXC_W-1:0] cexc, aexc, tem;
  logic [FTT_W-1:0] ftt;

  assign in_exec = (mode == MODE_EXEC);
  assign in_excp = (mode == MODE_EXCP);
  assign drain   = qstore_i & qne;
  assign mode_o  = mode;

  fpx_excp_unit i_excp (
    .clk_i, .rst_ni,
    .in_exec_i(in_exec), .in_excp_i(in_excp), .qne_i(qne),
    .qstore_i, .badreg_i, .unimpl_i, .arith_valid_i, .arith_flags_i,
    .issue_i, .tem_we_i, .tem_d_i,
    .raise_o(raise), .cexc_o(cexc), .aexc_o(aexc), .ftt_o(ftt), .tem_o(tem)
  );

  fpx_trap_queue #(.PC_W(PC_W), .INSN_W(INSN_W)) i_queue (
    .clk_i, .rst_ni,
    .capture_i(raise), .drain_i(drain), .pc_i, .insn_i,
    .qne_o(qne), .q_pc_o, .q_insn_o
  );

  fpx_mode_fsm i_fsm (
    .clk_i, .rst_ni,
    .raise_i(raise), .issue_i, .drain_i(drain), .wide_i, .ftt_i(ftt),
    .mode_o(mode), .trap_o, .trap_code_o
  );

  always_comb begin
    status_o = '0;
    status_o[CEXC_LSB +: EXC_W] = cexc;
    status_o[AEXC_LSB +: EXC_W] = aexc;
    status_o[QNE_BIT]           = qne;
    status_o[FTT_LSB +: FTT_W]  = ftt;
    status_o[VER_LSB +: VER_W]  = ver_sel_i;
    status_o[TEM_LSB +: EXC_W]  = tem;
  end

  assert_exec_queue_empty_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MODE_EXEC |-> !qne);

  assert_pend_queue_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MODE_PEND |-> qne);
endmodule

// File: tb/test_fpx_trap_ctrl.sv
module test_fpx_trap_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wide_i = 1'b0;
  logic [2:0]  ver_sel_i = 3'd5;
  logic [31:0] pc_i = '0, insn_i = '0;
  logic        arith_valid_i = 1'b0;
  logic [4:0]  arith_flags_i = '0;
  logic        unimpl_i = 1'b0, badreg_i = 1'b0, issue_i = 1'b0, qstore_i = 1'b0;
  logic        tem_we_i = 1'b0;
  logic [4:0]  tem_d_i = '0;
  logic [1:0]  mode_o;
  logic [31:0] status_o, q_pc_o, q_insn_o;
  logic        trap_o;
  logic [8:0]  trap_code_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fpx_trap_ctrl i_fpx_trap_ctrl (
    .clk_i(clk), .rst_ni, .wide_i, .ver_sel_i, .pc_i, .insn_i,
    .arith_valid_i, .arith_flags_i, .unimpl_i, .badreg_i, .issue_i, .qstore_i,
    .tem_we_i, .tem_d_i, .mode_o, .status_o, .trap_o, .trap_code_o, .q_pc_o, .q_insn_o
  );

  function automatic logic [31:0] st(input logic [4:0] c, input logic [4:0] a,
                                     input logic q, input logic [2:0] f, input logic [4:0] t);
    st = {4'b0, t, 3'b0, 3'd5, f, q, 3'b0, a, c};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    arith_valid_i = 0; unimpl_i = 0; badreg_i = 0; issue_i = 0; qstore_i = 0; tem_we_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 mode", {30'b0, mode_o}, 32'd0);
    chk("R1 status", status_o, st(0, 0, 0, 0, 0));
    chk("R1 trap", {31'b0, trap_o}, 32'd0);
  endtask

  task automatic t_tem();
    tem_we_i = 1; tem_d_i = 5'b00001; step(); idle();
    chk("R11 tem field", status_o, st(0, 0, 0, 0, 5'b00001));
  endtask

  task automatic t_arith_accrue();
    arith_valid_i = 1; arith_flags_i = 5'b10000; step(); idle();
    chk("R2 inexact", status_o, st(5'b10000, 5'b10000, 0, 0, 1));
    arith_valid_i = 1; arith_flags_i = 5'b01000; step(); idle();
    chk("R2 underflow", status_o, st(5'b01000, 5'b11000, 0, 0, 1));
    chk("R2 mode", {30'b0, mode_o}, 32'd0);
    arith_valid_i = 1; arith_flags_i = 5'b00000; step(); idle();
    chk("R2 cexc cleared", status_o, st(0, 5'b11000, 0, 0, 1));
  endtask

  task automatic t_arith_trap();
    pc_i = 32'h1000; insn_i = 32'h81a00020;
    arith_valid_i = 1; arith_flags_i = 5'b00001; step(); idle();
    chk("R3 status", status_o, st(5'b00001, 5'b11000, 1, 3'd1, 1));
    chk("R3 mode", {30'b0, mode_o}, 32'd1);
    chk("R3 q_pc", q_pc_o, 32'h1000);
    chk("R3 q_insn", q_insn_o, 32'h81a00020);
  endtask

  task automatic t_ignored_in_pend();
    pc_i = 32'h5555;
    arith_valid_i = 1; arith_flags_i = 5'b00010; step(); idle();
    unimpl_i = 1; step(); idle();
    badreg_i = 1; step(); idle();
    chk("R9 status", status_o, st(5'b00001, 5'b11000, 1, 3'd1, 1));
    chk("R9 q_pc", q_pc_o, 32'h1000);
    chk("R9 mode", {30'b0, mode_o}, 32'd1);
  endtask

  task automatic t_issue_trap(input logic w, input logic [8:0] code);
    wide_i = w; issue_i = 1; step(); idle();
    chk("R5 trap pulse", {31'b0, trap_o}, 32'd1);
    chk("R5 trap code", {23'b0, trap_code_o}, {23'b0, code});
    chk("R5 mode", {30'b0, mode_o}, 32'd2);
    step();
    chk("R5 pulse ends", {31'b0, trap_o}, 32'd0);
  endtask

  task automatic t_seq_in_excp();
    issue_i = 1; step(); idle();
    chk("R6 no trap", {31'b0, trap_o}, 32'd0);
    chk("R6 status", status_o, st(5'b00001, 5'b11000, 1, 3'd4, 1));
    chk("R6 mode", {30'b0, mode_o}, 32'd2);
    chk("R6 q_pc", q_pc_o, 32'h1000);
  endtask

  task automatic t_drain(input logic [31:0] epc, input logic [31:0] einsn, input logic [2:0] eftt);
    qstore_i = 1; step(); idle();
    chk("R8 mode", {30'b0, mode_o}, 32'd0);
    chk("R8 qne/ftt", status_o[16:13], {eftt, 1'b0});
    chk("R8 q_pc", q_pc_o, epc);
    chk("R8 q_insn", q_insn_o, einsn);
  endtask

  task automatic t_empty_store();
    pc_i = 32'h2004; insn_i = 32'hc1b80000;
    qstore_i = 1; step(); idle();
    chk("R7 status", status_o, st(5'b00001, 5'b11000, 1, 3'd4, 1));
    chk("R7 mode", {30'b0, mode_o}, 32'd1);
    chk("R7 q_pc", q_pc_o, 32'h2004);
  endtask

  task automatic t_unimpl();
    pc_i = 32'h3008; insn_i = 32'h81a01a20;
    unimpl_i = 1; step(); idle();
    chk("R4 unimpl ftt", status_o, st(5'b00001, 5'b11000, 1, 3'd3, 1));
    chk("R4 unimpl mode", {30'b0, mode_o}, 32'd1);
  endtask

  task automatic t_priority();
    pc_i = 32'h4000; insn_i = 32'h81a00940;
    badreg_i = 1; unimpl_i = 1; arith_valid_i = 1; arith_flags_i = 5'b00100; step(); idle();
    chk("R10 R4 badreg wins", status_o, st(5'b00001, 5'b11000, 1, 3'd6, 1));
    chk("R10 q_pc", q_pc_o, 32'h4000);
  endtask

  task automatic t_issue_exec();
    issue_i = 1; step(); idle();
    chk("R9 issue exec mode", {30'b0, mode_o}, 32'd0);
    chk("R9 issue exec trap", {31'b0, trap_o}, 32'd0);
    chk("R9 issue exec status", status_o, st(5'b00001, 5'b11000, 0, 3'd6, 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    step();
    t_reset();
    t_tem();
    t_arith_accrue();
    t_arith_trap();
    t_ignored_in_pend();
    t_issue_trap(1'b1, 9'h021);
    t_seq_in_excp();
    t_drain(32'h1000, 32'h81a00020, 3'd4);
    t_empty_store();
    t_issue_trap(1'b0, 9'h008);
    t_drain(32'h2004, 32'hc1b80000, 3'd4);
    t_unimpl();
    t_issue_trap(1'b1, 9'h022);
    t_drain(32'h3008, 32'h81a01a20, 3'd3);
    t_priority();
    t_drain(32'h4000, 32'h81a00940, 3'd6);
    t_issue_exec();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule